// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Word Processor

This block is a compact processor core that runs a program held in one external 1K-word unified memory. Every instruction and every datum is a single 16-bit word, and all arithmetic is two's-complement. The core contains a 10-bit program counter, an instruction register, a sixteen-entry register file, a four-function ALU and a control state machine. The state machine steps each instruction through the states FETCH, DECODE, EXEC, and then MEM and WB where the instruction needs them. A HALT state parks the core until the next reset.

The memory is outside the block. The core drives a 10-bit word address, a 16-bit write-data bus and a write strobe, and it takes read data back combinationally in the same cycle. A debug selector picks any of the sixteen registers, and the debug output shows that register's contents at all times, whatever the program is doing.

State transitions: FETCH→DECODE always. DECODE→EXEC always. EXEC→WB for ALU operations and add-immediate. EXEC→MEM for load and store. EXEC→HALT for halt. EXEC→FETCH for branches, jumps, calls and register jumps. MEM→WB for load, and MEM→FETCH for store. WB→FETCH always. HALT→HALT until reset.

Top module: `mcpu16_core`

## Requirements
- R1: In FETCH the core presents the program counter on `mem_addr`, loads the instruction register from `mem_rdata` and increments the PC modulo 1024. In every state except MEM and HALT, `mem_addr` shows the PC. In HALT it shows the frozen PC.
- R2: Opcodes 0 (add), 1 (subtract), 2 (AND) and 3 (OR) use bits [11:8] as destination, [7:4] as first source and [3:0] as second source, and write dst = src1 op src2. Opcode 4 writes dst = src1 + sign-extended imm[3:0].
- R3: Register 0 always reads as zero, on the debug port as well. Any write to it is discarded.
- R4: Opcode 5 (load) reads memory at the address (src1 + sign-extended imm[3:0]) modulo 1024 into register [11:8]. Opcode 6 (store) writes register [11:8] to that address. `mem_we` is high only during the MEM cycle of a store, with `mem_wdata` equal to the stored register.
- R5: Opcodes 7..12 compare register [11:8] (a) with register [7:4] (b) as signed values: 7 a==b, 8 a!=b, 9 a<b, 10 a>=b, 11 a<=b, 12 a>b. When the test holds, the next PC is (branch address + 1 + sign-extended off[3:0]) mod 1024. When it fails, the next PC is the branch address + 1.
- R6: Opcode 13 jumps to bits [9:0]. Opcode 14 writes (its own address + 1) into register 15 and jumps to bits [9:0]. Opcode 15 with bit 0 set jumps to the low 10 bits of register [11:8].
- R7: Opcode 15 with bit 0 clear halts the core. After that no fetch takes place, `mem_we` stays low and `mem_addr` holds the halt address + 1 until reset.
- R8: `dbg_value` shows the register chosen by `dbg_sel` combinationally. A register written at the end of a cycle shows its old value during that cycle and its new value from the next cycle on.
- R9: An active-low asynchronous reset puts the core in FETCH with PC = 0, clears every register and the instruction register, and keeps `mem_we` low.
- R10: ALU and add-immediate instructions take 4 cycles, loads take 5, stores take 4 (the write falls in the 4th), and branches, jumps, calls, register jumps and halt take 3 cycles before the next fetch or the HALT state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 10 | Word address to the unified memory |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Write strobe, one cycle per store |
| dbg_sel | input | 4 | Register chosen for observation |
| dbg_value | output | 16 | Contents of the chosen register |

## Verification
The register writeback and the debug port's combinational view of the same register can fall in the same cycle. To provoke this, the bench steers `dbg_sel` to the destination of the instruction in flight on every cycle. It then expects the old contents during the WB cycle (or during EXEC for a call) and the new contents from the next cycle on. A cycle-accurate reference model judges this, and it also compares the fetch addresses, the store strobes and the store data on every clock across a program with all six branch tests taken and not taken, a loop, a call and return, and a halt. A sweep after the halt then checks every register against values worked out by hand.

// File: rtl/mcpu16_pkg.sv
package mcpu16_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB,
        ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        OP_ADD,  OP_SUB,  OP_AND,  OP_OR,
        OP_ADDI, OP_LW,   OP_SW,   OP_BEQ,
        OP_BNE,  OP_BLT,  OP_BGE,  OP_BLE,
        OP_BGT,  OP_JMP,  OP_JAL,  OP_SYS
    } op_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } aluop_e;

    typedef struct packed {
        logic ir_ld;
        logic ab_ld;
        logic res_ld;
        logic mdr_ld;
        logic pc_inc;
        logic pc_rel;
        logic pc_abs;
        logic pc_reg;
        logic rf_we;
        logic rf_link;
        logic mem_we;
        logic addr_res;
    } ctl_t;

endpackage

// File: rtl/mcpu16_regfile.sv
module mcpu16_regfile #(
    parameter int DW  = 16,
    parameter int RW  = 4,
    parameter int NRD = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][RW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata,
    input  logic                    we,
    input  logic [RW-1:0]           waddr,
    input  logic [DW-1:0]           wdata
);
    localparam int NREG = 1 << RW;

    logic [DW-1:0] store_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                store_q[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            store_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rport
        assign rdata[p] = (raddr[p] == '0) ? '0 : store_q[raddr[p]];
    end

endmodule

// File: rtl/mcpu16_alu.sv
module mcpu16_alu
    import mcpu16_pkg::*;
#(
    parameter int DW = 16
) (
    input  aluop_e          op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y,
    output logic            zero,
    output logic            lt
);
    logic [DW-1:0] diff;
    logic          ovf;

    assign diff = a - b;
    assign ovf  = (a[DW-1] ^ b[DW-1]) & (diff[DW-1] ^ a[DW-1]);
    assign lt   = diff[DW-1] ^ ovf;
    assign zero = (diff == '0);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/mcpu16_ctrl.sv
module mcpu16_ctrl
    import mcpu16_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  op_e     op,
    input  logic    jr_sel,
    input  logic    take,
    output state_e  state,
    output ctl_t    ctl
);
    state_e state_q, state_d;

    assign state = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (op)
                    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_ADDI: state_d = ST_WB;
                    OP_LW, OP_SW:                           state_d = ST_MEM;
                    OP_SYS:  state_d = jr_sel ? ST_FETCH : ST_HALT;
                    default: state_d = ST_FETCH;
                endcase
            end
            ST_MEM:    state_d = (op == OP_LW) ? ST_WB : ST_FETCH;
            ST_WB:     state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_FETCH;
        endcase
    end

    // control outputs
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_FETCH: begin
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_DECODE: ctl.ab_ld = 1'b1;
            ST_EXEC: begin
                ctl.res_ld = 1'b1;
                unique case (op)
                    OP_BEQ, OP_BNE, OP_BLT, OP_BGE, OP_BLE, OP_BGT:
                        ctl.pc_rel = take;
                    OP_JMP: ctl.pc_abs = 1'b1;
                    OP_JAL: begin
                        ctl.pc_abs  = 1'b1;
                        ctl.rf_we   = 1'b1;
                        ctl.rf_link = 1'b1;
                    end
                    OP_SYS:  ctl.pc_reg = jr_sel;
                    default: ctl.res_ld = 1'b1;
                endcase
            end
            ST_MEM: begin
                ctl.addr_res = 1'b1;
                ctl.mem_we   = (op == OP_SW);
                ctl.mdr_ld   = (op == OP_LW);
            end
            ST_WB:   ctl.rf_we = 1'b1;
            ST_HALT: ctl = '0;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mcpu16_core.sv
module mcpu16_core
    import mcpu16_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 10,
    parameter int RW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_we,
    input  logic [RW-1:0]   dbg_sel,
    output logic [DW-1:0]   dbg_value
);
    localparam int NREG   = 1 << RW;
    localparam int LINK   = NREG - 1;
    localparam int OPW    = 4;
    localparam int OP_LSB = DW - OPW;
    localparam int RD_LSB = OP_LSB - RW;
    localparam int RS_LSB = RD_LSB - RW;
    localparam int RT_LSB = RS_LSB - RW;
    localparam int NRD    = 3;

    state_e          state_q;
    ctl_t            ctl;
    logic [AW-1:0]   pc_q;
    logic [DW-1:0]   ir_q, a_q, b_q, res_q, mdr_q;

    op_e             op;
    logic [RW-1:0]   rd_f, rs_f, rt_f;
    logic            is_rtype, is_branch, take;
    logic [DW-1:0]   simm;
    logic [AW-1:0]   boff;

    logic [NRD-1:0][RW-1:0] rf_ra;
    logic [NRD-1:0][DW-1:0] rf_rd;
    logic [RW-1:0]   rf_wa;
    logic [DW-1:0]   rf_wd;

    aluop_e          alu_op;
    logic [DW-1:0]   alu_b, alu_y;
    logic            alu_zero, alu_lt;

    // instruction fields
    assign op        = op_e'(ir_q[DW-1:OP_LSB]);
    assign rd_f      = ir_q[RD_LSB +: RW];
    assign rs_f      = ir_q[RS_LSB +: RW];
    assign rt_f      = ir_q[RT_LSB +: RW];
    assign simm      = {{(DW-RW){ir_q[RW-1]}}, ir_q[RW-1:0]};
    assign boff      = {{(AW-RW){ir_q[RW-1]}}, ir_q[RW-1:0]};
    assign is_rtype  = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR);
    assign is_branch = (op == OP_BEQ) || (op == OP_BNE) || (op == OP_BLT) ||
                       (op == OP_BGE) || (op == OP_BLE) || (op == OP_BGT);

    mcpu16_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .jr_sel (ir_q[0]),
        .take   (take),
        .state  (state_q),
        .ctl    (ctl)
    );

    // register read address steering: port 0 first operand, 1 second, 2 debug
    always_comb begin
        rf_ra[0] = (is_branch || op == OP_SYS) ? rd_f : rs_f;
        if (is_rtype)       rf_ra[1] = rt_f;
        else if (is_branch) rf_ra[1] = rs_f;
        else                rf_ra[1] = rd_f;
        rf_ra[2] = dbg_sel;
    end

    assign rf_wa = ctl.rf_link ? RW'(LINK) : rd_f;
    assign rf_wd = ctl.rf_link    ? {{(DW-AW){1'b0}}, pc_q} :
                   (op == OP_LW)  ? mdr_q : res_q;

    mcpu16_regfile #(.DW(DW), .RW(RW), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (rf_ra),
        .rdata (rf_rd),
        .we    (ctl.rf_we),
        .waddr (rf_wa),
        .wdata (rf_wd)
    );

    assign dbg_value = rf_rd[2];

    // ALU operand and function selection
    always_comb begin
        if (is_rtype)       alu_op = aluop_e'(ir_q[OP_LSB +: 2]);
        else if (is_branch) alu_op = ALU_SUB;
        else                alu_op = ALU_ADD;
    end
    assign alu_b = (is_rtype || is_branch) ? b_q : simm;

    mcpu16_alu #(.DW(DW)) u_alu (
        .op   (alu_op),
        .a    (a_q),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero),
        .lt   (alu_lt)
    );

    // signed relational test on the subtract flags
    always_comb begin
        unique case (op)
            OP_BEQ:  take = alu_zero;
            OP_BNE:  take = !alu_zero;
            OP_BLT:  take = alu_lt;
            OP_BGE:  take = !alu_lt;
            OP_BLE:  take = alu_lt || alu_zero;
            OP_BGT:  take = !(alu_lt || alu_zero);
            default: take = 1'b0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            if (ctl.ir_ld)  ir_q  <= mem_rdata;
            if (ctl.ab_ld) begin
                a_q <= rf_rd[0];
                b_q <= rf_rd[1];
            end
            if (ctl.res_ld) res_q <= alu_y;
            if (ctl.mdr_ld) mdr_q <= mem_rdata;
            if (ctl.pc_inc)      pc_q <= pc_q + 1'b1;
            else if (ctl.pc_rel) pc_q <= pc_q + boff;
            else if (ctl.pc_abs) pc_q <= ir_q[AW-1:0];
            else if (ctl.pc_reg) pc_q <= a_q[AW-1:0];
        end
    end

    assign mem_addr  = ctl.addr_res ? res_q[AW-1:0] : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/mcpu16_checker.sv
module mcpu16_checker
    import mcpu16_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 10,
    parameter int RW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  state_e          state,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   mem_addr,
    input  logic            mem_we,
    input  logic [RW-1:0]   dbg_sel,
    input  logic [DW-1:0]   dbg_value
);

    assert_fetch_advances_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc == AW'($past(pc) + 1'b1)));

    assert_zero_reg_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == '0) |-> (dbg_value == '0));

    assert_write_only_in_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_MEM));

    assert_halt_is_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> ((state == ST_HALT) && $stable(mem_addr) && !mem_we));

    assert_decode_follows_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |-> ($past(state) == ST_FETCH));

    assert_exec_follows_decode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |-> ($past(state) == ST_DECODE));

endmodule

bind mcpu16_core mcpu16_checker #(.DW(DW), .AW(AW), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .pc        (pc_q),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .dbg_sel   (dbg_sel),
    .dbg_value (dbg_value)
);

// File: tb/tb_mcpu16_core.sv
module tb_mcpu16_core;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int RW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata, mem_wdata, dbg_value;
    logic          mem_we;
    logic [RW-1:0] dbg_sel = '0;

    always #5 clk = ~clk;

    mcpu16_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .dbg_sel   (dbg_sel),
        .dbg_value (dbg_value)
    );

    // external memory
    logic [DW-1:0] mem [DEPTH];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    // reference model state
    logic [15:0] rreg [16];
    logic [15:0] rmem [DEPTH];
    int rpc, phase, plen, pwreg, paddr, pnpc, cyc;
    logic [15:0] pwval, pdata;
    bit pstore, phalt, rhalt, done;
    int nchk = 0, nfail = 0;

    function automatic logic [15:0] rr(input int i);
        return (i == 0) ? 16'h0 : rreg[i];
    endfunction

    function automatic logic [15:0] enc(input int op, input int a, input int b, input int c);
        return {op[3:0], a[3:0], b[3:0], c[3:0]};
    endfunction

    function automatic logic [15:0] encj(input int op, input int addr);
        return {op[3:0], 2'b00, addr[9:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic put(input int a, input logic [15:0] w);
        mem[a] = w;
        rmem[a] = w;
    endtask

    task automatic model_begin();
        logic [15:0] ins;
        int op, f1, f2, s;
        bit t;
        ins = rmem[rpc];
        op = int'(ins[15:12]);
        f1 = int'(ins[11:8]);
        f2 = int'(ins[7:4]);
        s  = int'(ins[3:0]);
        if (s > 7) s -= 16;
        pstore = 0; phalt = 0; pwreg = -1; pnpc = (rpc + 1) & 1023; plen = 3;
        case (op)
            0, 1, 2, 3: begin
                plen = 4; pwreg = f1;
                case (op)
                    0: pwval = rr(f2) + rr(int'(ins[3:0]));
                    1: pwval = rr(f2) - rr(int'(ins[3:0]));
                    2: pwval = rr(f2) & rr(int'(ins[3:0]));
                    default: pwval = rr(f2) | rr(int'(ins[3:0]));
                endcase
            end
            4: begin plen = 4; pwreg = f1; pwval = rr(f2) + 16'(s); end
            5: begin
                plen = 5; pwreg = f1;
                paddr = (int'(rr(f2)) + s) & 1023;
                pwval = rmem[paddr];
            end
            6: begin
                plen = 4; pstore = 1;
                paddr = (int'(rr(f2)) + s) & 1023;
                pdata = rr(f1);
            end
            7, 8, 9, 10, 11, 12: begin
                case (op)
                    7:  t = ($signed(rr(f1)) == $signed(rr(f2)));
                    8:  t = ($signed(rr(f1)) != $signed(rr(f2)));
                    9:  t = ($signed(rr(f1)) <  $signed(rr(f2)));
                    10: t = ($signed(rr(f1)) >= $signed(rr(f2)));
                    11: t = ($signed(rr(f1)) <= $signed(rr(f2)));
                    default: t = ($signed(rr(f1)) > $signed(rr(f2)));
                endcase
                if (t) pnpc = (rpc + 1 + s) & 1023;
            end
            13: pnpc = int'(ins[9:0]);
            14: begin pwreg = 15; pwval = 16'((rpc + 1) & 1023); pnpc = int'(ins[9:0]); end
            default: begin
                if (ins[0]) pnpc = int'(rr(f1)) & 1023;
                else phalt = 1;
            end
        endcase
    endtask

    task automatic model_commit();
        if (pwreg > 0) rreg[pwreg] = pwval;
        if (pstore) rmem[paddr] = pdata;
        rpc = pnpc;
        if (phalt) rhalt = 1;
        phase = 0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) rreg[i] = 16'h0;
        rpc = 0; phase = 0; rhalt = 0; pwreg = -1; pstore = 0;
    endtask

    // one cycle: steer debug port, sample away from the edge, compare, advance
    task automatic step();
        bit exp_we;
        if (!rhalt && phase == 0) model_begin();
        if (!rhalt && pwreg > 0) dbg_sel = pwreg[3:0];
        else dbg_sel = 4'(cyc);
        cyc++;
        #1;
        if (rhalt) begin
            chk(mem_we == 1'b0, "R7 no write after halt", 32'(mem_we), 32'd0);
            chk(mem_addr == 10'(rpc), "R7 address frozen after halt", 32'(mem_addr), 32'(rpc));
        end else begin
            exp_we = pstore && (phase == 3);
            chk(mem_we == exp_we, "R4 R10 write strobe timing", 32'(mem_we), 32'(exp_we));
            if (phase == 0)
                chk(mem_addr == 10'(rpc), "R1 R10 fetch address", 32'(mem_addr), 32'(rpc));
            if (exp_we) begin
                chk(mem_addr == 10'(paddr), "R4 store address", 32'(mem_addr), 32'(paddr));
                chk(mem_wdata == pdata, "R4 store data", 32'(mem_wdata), 32'(pdata));
            end
        end
        chk(dbg_value == rr(int'(dbg_sel)), "R8 debug view vs writeback", 32'(dbg_value),
            32'(rr(int'(dbg_sel))));
        if (!rhalt) begin
            phase++;
            if (phase == plen) model_commit();
        end
        @(negedge clk);
    endtask

    function automatic logic [15:0] hand_val(input int i);
        case (i)
            1: return 16'h0005;  2: return 16'hFFFD;  3: return 16'h0002;
            4: return 16'hFFF8;  5: return 16'h0005;  6: return 16'hFFFD;
            7: return 16'h0000;  8: return 16'h0005;  9: return 16'h1234;
            10: return 16'hFFFD; 11: return 16'h000B; 12: return 16'h0014;
            13: return 16'h0006; 14: return 16'h0000; 15: return 16'h0029;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string hand_tag(input int i);
        case (i)
            0: return "R3 zero register after write attempt";
            8, 9, 10: return "R4 load result";
            13, 14: return "R5 branch outcome counters";
            11, 15: return "R6 call and return";
            default: return "R2 ALU result";
        endcase
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int extra;
        done = 0; cyc = 0;
        for (int i = 0; i < DEPTH; i++) put(i, 16'h0);
        put(0,  enc(4, 1, 0, 5));
        put(1,  enc(4, 2, 0, -3));
        put(2,  enc(0, 3, 1, 2));
        put(3,  enc(1, 4, 2, 1));
        put(4,  enc(2, 5, 1, 2));
        put(5,  enc(3, 6, 4, 1));
        put(6,  enc(4, 0, 1, 7));
        put(7,  enc(6, 1, 4, 2));
        put(8,  enc(6, 6, 4, -1));
        put(9,  enc(5, 8, 4, 2));
        put(10, enc(5, 9, 4, 4));
        put(11, enc(5, 10, 4, -1));
        put(12, enc(9, 2, 1, 1));   put(13, enc(4, 14, 14, 1));
        put(14, enc(9, 1, 2, 1));   put(15, enc(4, 13, 13, 1));
        put(16, enc(12, 1, 2, 1));  put(17, enc(4, 14, 14, 1));
        put(18, enc(12, 2, 1, 1));  put(19, enc(4, 13, 13, 1));
        put(20, enc(7, 8, 1, 1));   put(21, enc(4, 14, 14, 1));
        put(22, enc(7, 1, 2, 1));   put(23, enc(4, 13, 13, 1));
        put(24, enc(8, 1, 2, 1));   put(25, enc(4, 14, 14, 1));
        put(26, enc(8, 8, 1, 1));   put(27, enc(4, 13, 13, 1));
        put(28, enc(11, 8, 1, 1));  put(29, enc(4, 14, 14, 1));
        put(30, enc(11, 1, 2, 1));  put(31, enc(4, 13, 13, 1));
        put(32, enc(10, 8, 1, 1));  put(33, enc(4, 14, 14, 1));
        put(34, enc(10, 2, 1, 1));  put(35, enc(4, 13, 13, 1));
        put(36, enc(4, 7, 0, 4));
        put(37, enc(0, 12, 12, 1));
        put(38, enc(4, 7, 7, -1));
        put(39, enc(8, 7, 0, -3));
        put(40, encj(14, 50));
        put(41, enc(4, 11, 11, 1));
        put(42, encj(13, 45));
        put(43, enc(4, 14, 14, 1));
        put(44, enc(4, 14, 14, 1));
        put(45, enc(15, 0, 0, 0));
        put(50, enc(0, 11, 1, 1));
        put(51, enc(15, 15, 0, 1));
        put(1020, 16'h1234);

        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        dbg_sel = 4'd1;
        #1;
        chk(mem_we == 1'b0, "R9 write strobe low in reset", 32'(mem_we), 32'd0);
        chk(mem_addr == '0, "R9 PC zero in reset", 32'(mem_addr), 32'd0);
        chk(dbg_value == '0, "R9 register cleared in reset", 32'(dbg_value), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        extra = 0;
        for (int k = 0; k < 3000 && extra < 10; k++) begin
            step();
            if (rhalt) extra++;
        end
        chk(rhalt, "R7 halt reached", 32'(rhalt), 32'd1);

        for (int i = 0; i < 16; i++) begin
            dbg_sel = 4'(i);
            #1;
            chk(dbg_value == hand_val(i), hand_tag(i), 32'(dbg_value), 32'(hand_val(i)));
        end
        chk(mem[1018] == 16'h0005, "R4 stored word in memory", 32'(mem[1018]), 32'h5);
        chk(mem[1015] == 16'hFFFD, "R4 stored word at negative offset", 32'(mem[1015]), 32'hFFFD);

        // reset out of halt, run part of the program, then reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(mem_addr == '0, "R9 reset leaves halt", 32'(mem_addr), 32'd0);
        dbg_sel = 4'd15;
        #1;
        chk(dbg_value == '0, "R9 link register cleared", 32'(dbg_value), 32'd0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 30; k++) step();
        rst_n = 1'b0;
        dbg_sel = 4'd1;
        #1;
        chk(dbg_value == '0, "R9 mid-run reset clears registers", 32'(dbg_value), 32'd0);
        chk(mem_we == 1'b0, "R9 mid-run reset write strobe", 32'(mem_we), 32'd0);

        done = 1;
        summary();
        $finish;
    end

endmodule